// File: doc/BRIEF.md
# Pulse Add/Skip Frequency Trimmer

This block trims the average rate of a 32.768 kHz timekeeping tick by whole ppm steps. The raw oscillator arrives as a one-cycle tick enable in the system clock domain. A 3-bit signed trim code says whether ticks are to be added or removed, and how many. Input ticks are counted in fixed correction windows, 100,000 ticks by default. Within each window the block inserts or deletes one tick per magnitude step. At the default window length that is a 10 ppm shift per step, so the range is plus or minus 30 ppm. Corrected ticks feed a divider whose carry is the once-per-second pulse.

The trim code is sign-magnitude. Bit 2 set means add ticks and bit 2 clear means skip ticks. Bits 1:0 give the magnitude, 0 to 3. The code is sampled only on the last input tick of a window. Corrections are spread through the window by an error accumulator.

The output shaper is a two-state machine. In SH_PASS a real tick passes to the output, or is suppressed if it is due for skipping. The transition SH_PASS to SH_EXTRA is taken on a real tick that is due for an added correction. SH_EXTRA emits the inserted tick and always returns to SH_PASS. Input ticks must be at least two clock cycles apart, so that no tick arrives while SH_EXTRA is being served.

Top module: `ppm_tick_trimmer`

## Requirements
- R1: Reset (rst_n low, asynchronous) drives tick_out and pps_out low, clears the window and divider counts, and makes the active code zero, so the first window after reset has no correction whatever trim_code holds.
- R2: With magnitude zero (code 000 or 100) every input tick gives exactly one tick_out pulse one cycle later, and no other tick_out pulse occurs.
- R3: With bit 2 set and magnitude m (1 to 3), a window of WINDOW input ticks yields WINDOW+m corrected ticks.
- R4: With bit 2 clear and magnitude m (1 to 3), a window of WINDOW input ticks yields WINDOW-m corrected ticks.
- R5: The correction falls on in-window tick i (counted 1 to WINDOW) exactly when floor(i*m/WINDOW) exceeds floor((i-1)*m/WINDOW).
- R6: An inserted tick shows on tick_out in the cycle after the real tick's own output pulse, which is two cycles after tick_in. tick_in must be low in the cycle that follows a tick.
- R7: A skipped input tick produces no tick_out pulse.
- R8: trim_code is taken only on the last input tick of a window. A change at any other time has no effect until the next window begins.
- R9: pps_out pulses for one cycle, in the cycle after every DIV-th corrected tick counted since reset. DIV is 32768 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle raw oscillator tick enable |
| trim_code | input | 3 | Bit 2: add (1) or skip (0); bits 1:0: magnitude |
| tick_out | output | 1 | Corrected tick enable |
| pps_out | output | 1 | One-cycle pulse every DIV corrected ticks |

## Verification
A pass-through tick appears on tick_out one cycle after the edge that samples tick_in. An inserted tick appears one cycle later again. pps_out follows the corrected tick that completes a group by one further cycle. The bench drives each tick at a falling edge and samples at the next three falling edges: the real output, the inserted output with the pps of the real tick, and the pps of the inserted tick. Its own model of window position and latched code gives the expected level at each of those samples, and per-window totals are compared after whole windows.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int MAG_W  = 2;
    localparam int CODE_W = MAG_W + 1;

    typedef struct packed {
        logic             add;
        logic [MAG_W-1:0] mag;
    } trim_code_t;

    typedef enum logic {
        SH_PASS  = 1'b0,
        SH_EXTRA = 1'b1
    } shape_state_e;
endpackage

// File: rtl/trim_window_sched.sv
module trim_window_sched
    import trim_pkg::*;
#(
    parameter int WINDOW = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  trim_code_t code_in,
    output logic       corr_hit,
    output logic       corr_add
);
    localparam int WIN_W = $clog2(WINDOW);
    localparam int ACC_W = $clog2(WINDOW + (1 << MAG_W));

    logic [WIN_W-1:0] win_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    trim_code_t       act_q;
    logic             last_tick;

    assign last_tick = tick_in && (win_q == WIN_W'(WINDOW - 1));
    assign acc_sum   = acc_q + ACC_W'(act_q.mag);
    assign corr_hit  = tick_in && (acc_sum >= ACC_W'(WINDOW));
    assign corr_add  = act_q.add;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            acc_q <= '0;
            act_q <= '0;
        end else if (tick_in) begin
            if (last_tick) begin
                win_q <= '0;
                acc_q <= '0;
                act_q <= code_in;
            end else begin
                win_q <= win_q + 1'b1;
                acc_q <= corr_hit ? (acc_sum - ACC_W'(WINDOW)) : acc_sum;
            end
        end
    end

    // Correction tally per window, kept for the checks below.
    logic [MAG_W:0] corr_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            corr_cnt_q <= '0;
        else if (last_tick)
            corr_cnt_q <= '0;
        else if (corr_hit)
            corr_cnt_q <= corr_cnt_q + 1'b1;
    end

    // R3 and R4: a window closes with exactly magnitude corrections
    a_r3_corr_total: assert property (@(posedge clk) disable iff (!rst_n)
        last_tick |-> ((corr_cnt_q + (MAG_W+1)'(corr_hit)) == (MAG_W+1)'(act_q.mag)));

    // R8: the active code moves only on a window's last tick
    a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last_tick |=> $stable(act_q));
endmodule

// File: rtl/trim_tick_shaper.sv
module trim_tick_shaper
    import trim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic corr_hit,
    input  logic corr_add,
    output logic tick_out
);
    shape_state_e state_q;
    shape_state_e state_d;
    logic         out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SH_PASS;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_PASS:  if (tick_in && corr_hit && corr_add) state_d = SH_EXTRA;
            SH_EXTRA: state_d = SH_PASS;
            default:  state_d = SH_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= 1'b0;
        else begin
            unique case (state_q)
                SH_PASS:  out_q <= tick_in && !(corr_hit && !corr_add);
                SH_EXTRA: out_q <= 1'b1;
                default:  out_q <= 1'b0;
            endcase
        end
    end

    assign tick_out = out_q;

    // R2: an uncorrected tick reaches the output next cycle
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && !corr_hit) |=> tick_out);

    // R7: a skipped tick leaves the output low
    a_r7_skip_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && corr_hit && !corr_add) |=> !tick_out);

    // R6: an added correction gives two back-to-back output pulses
    a_r6_extra_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && corr_hit && corr_add) |=> (tick_out ##1 tick_out));

    // R6: no input tick while the inserted tick is being emitted
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_EXTRA) |-> !tick_in);
endmodule

// File: rtl/trim_sec_divider.sv
module trim_sec_divider #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic pps
);
    localparam int DIV_W = $clog2(DIV);

    logic [DIV_W-1:0] cnt_q;
    logic             pps_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pps_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == DIV_W'(DIV - 1)) begin
                cnt_q <= '0;
                pps_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                pps_q <= 1'b0;
            end
        end else begin
            pps_q <= 1'b0;
        end
    end

    assign pps = pps_q;

    // R9: a pulse always follows a corrected tick
    a_r9_pps_source: assert property (@(posedge clk) disable iff (!rst_n)
        pps_q |-> $past(tick));
endmodule

// File: rtl/ppm_tick_trimmer.sv
module ppm_tick_trimmer
    import trim_pkg::*;
#(
    parameter int WINDOW = 100000,
    parameter int DIV    = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [CODE_W-1:0] trim_code,
    output logic              tick_out,
    output logic              pps_out
);
    trim_code_t code_s;
    logic       corr_hit;
    logic       corr_add;
    logic       tick_fix;

    assign code_s = trim_code;

    trim_window_sched #(.WINDOW(WINDOW)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_in),
        .code_in  (code_s),
        .corr_hit (corr_hit),
        .corr_add (corr_add)
    );

    trim_tick_shaper u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_in),
        .corr_hit (corr_hit),
        .corr_add (corr_add),
        .tick_out (tick_fix)
    );

    trim_sec_divider #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_fix),
        .pps   (pps_out)
    );

    assign tick_out = tick_fix;
endmodule

// File: tb/ppm_tick_trimmer_test.sv
`timescale 1ns/1ps
module ppm_tick_trimmer_test;
    localparam int W   = 60;
    localparam int DIV = 50;
    localparam int NVEC = 8;
    // {code, expected change in corrected ticks per window}
    localparam int VEC [NVEC][2] = '{
        '{0, 0}, '{5, 1}, '{6, 2}, '{7, 3},
        '{1, -1}, '{2, -2}, '{3, -3}, '{4, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic [2:0] trim_code = 3'b000;
    logic       tick_out;
    logic       pps_out;

    int checks = 0;
    int errors = 0;
    int win_idx = 0;
    int out_cnt = 0;
    int win_obs = 0;
    logic [2:0] act_code = 3'b000;

    always #2 clk = ~clk;

    ppm_tick_trimmer #(.WINDOW(W), .DIV(DIV)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .trim_code (trim_code),
        .tick_out  (tick_out),
        .pps_out   (pps_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // One input tick, starting and ending at a falling edge.
    task automatic do_tick();
        int   i;
        int   mag;
        bit   corr;
        bit   add;
        bit   real_e;
        bit   extra_e;
        bit   pps_r;
        bit   pps_x;
        string rtag;
        i     = win_idx + 1;
        mag   = int'(act_code[1:0]);
        add   = act_code[2];
        corr  = (mag != 0) && (((i * mag) / W) != (((i - 1) * mag) / W));
        real_e  = !(corr && !add);
        extra_e = corr && add;
        pps_r = 1'b0;
        pps_x = 1'b0;
        if (real_e) begin
            out_cnt++;
            if (out_cnt % DIV == 0) pps_r = 1'b1;
        end
        if (extra_e) begin
            out_cnt++;
            if (out_cnt % DIV == 0) pps_x = 1'b1;
        end
        rtag = corr ? (add ? "R5 add" : "R5/R7 skip") : "R2 pass";
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        chk(rtag, tick_out, real_e);
        chk("R9 idle", pps_out, 1'b0);
        if (tick_out) win_obs++;
        @(negedge clk);
        chk("R6 inserted", tick_out, extra_e);
        chk("R9 after real", pps_out, pps_r);
        if (tick_out) win_obs++;
        @(negedge clk);
        chk("R6 quiet", tick_out, 1'b0);
        chk("R9 after inserted", pps_out, pps_x);
        if (win_idx == W - 1) begin
            win_idx  = 0;
            act_code = trim_code;
        end else begin
            win_idx++;
        end
    endtask

    task automatic run_ticks(input int n);
        for (int k = 0; k < n; k++) do_tick();
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs quiet in reset
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset tick_out", tick_out, 1'b0);
        chk("R1 reset pps_out", pps_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: load code over one window, measure the next
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            trim_code = 3'(VEC[v][0]);
            run_ticks(W);
            win_obs = 0;
            run_ticks(W);
            tag = (VEC[v][1] > 0) ? "R3 window total" :
                  (VEC[v][1] < 0) ? "R4 window total" : "R2 window total";
            chk_int(tag, win_obs, W + VEC[v][1]);
        end

        // R8: codes written mid-window; only the last value counts
        trim_code = 3'b011;
        win_obs = 0;
        run_ticks(W / 2);
        trim_code = 3'b110;
        run_ticks(W - W / 2);
        chk_int("R8 window before load", win_obs, W);
        win_obs = 0;
        run_ticks(W);
        chk_int("R8 window after load", win_obs, W + 2);

        // R1: reset mid-window restores code zero
        trim_code = 3'b111;
        run_ticks(20);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset tick_out", tick_out, 1'b0);
        chk("R1 mid reset pps_out", pps_out, 1'b0);
        rst_n = 1'b1;
        win_idx  = 0;
        out_cnt  = 0;
        act_code = 3'b000;
        @(negedge clk);
        win_obs = 0;
        run_ticks(W);
        chk_int("R1 first window after reset", win_obs, W);
        win_obs = 0;
        run_ticks(W);
        chk_int("R3 window after reset", win_obs, W + 3);

        summary();
        $finish;
    end
endmodule